// File: doc/BRIEF.md
# Maskable Dual Time Alarm

This block watches a running BCD clock and raises sticky flags when the time reaches one of two programmed alarm settings. The first alarm compares seconds, minutes, hours and a day field. The second alarm has no seconds setting; it compares minutes, hours and the day field, and it is only considered at the top of a minute. Every alarm setting byte carries a mask bit. A masked field always counts as matching, so one alarm can be made to fire every second, minute, hour, day or date.

Comparisons are evaluated on every clock cycle, but a flag is only set on a cycle where the once-per-second update strobe is high. Once set, a flag stays set until the host writes a zero to its bit. An active-low interrupt line combines the flags with per-alarm enables when interrupt mode is selected. The time counters and the register access path live outside this block.

Top module: `dual_alarm_match`

## Requirements
- R1: While reset is low and on the first cycle after it, both flags read 0 and irq_n reads 1.
- R2: Alarm 1 matches when each of its seconds, minutes and hours bytes equals the current time field in bits 6:0. A byte with bit 7 set always matches. The hours byte is compared over all seven bits, so bit 6 (12/24 mode) and bit 5 (PM or tens of hours) take part.
- R3: In an alarm day byte with bit 7 clear, bit 6 set compares bits 3:0 against {1'b0, day of week}; bit 6 clear compares bits 5:0 against the BCD date.
- R4: flags bit 0 belongs to alarm 1 and bit 1 to alarm 2. A flag is set on the clock edge where tick is high and its alarm matches, and not otherwise; once set it holds.
- R5: Alarm 2 compares its minutes, hours and day bytes like alarm 1, and matches only while the seconds input equals 7'h00.
- R6: With flag_wr high, a 0 in a bit of flag_wdata clears that flag and a 1 leaves it unchanged.
- R7: When a match with tick and a clearing write hit the same flag in the same cycle, the flag ends set.
- R8: irq_n is low exactly when int_mode is 1 and some flag is set whose enable bit (ie bit 0 for alarm 1, bit 1 for alarm 2) is 1; with int_mode 0 irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Once-per-second update strobe |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours byte: bit 6 mode, bit 5 PM/tens, BCD |
| now_wday | input | 3 | Current day of week, 1 to 7 |
| now_mday | input | 6 | Current date, BCD |
| a1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| a1_day | input | 8 | Alarm 1 day, bit 7 mask, bit 6 day/date select |
| a2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| a2_day | input | 8 | Alarm 2 day, bit 7 mask, bit 6 day/date select |
| ie | input | 2 | Interrupt enables, bit 0 alarm 1, bit 1 alarm 2 |
| int_mode | input | 1 | Route flags to irq_n when 1 |
| flag_wr | input | 1 | Host write strobe for the flags |
| flag_wdata | input | 2 | Write data, 0 clears a flag |
| flags | output | 2 | Sticky alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions watch, on every cycle, that a flag only rises after a strobe, that alarm 2 only rises after a zero seconds value, that a strobed match always sets its flag, that a flag holds unless a clearing write arrives and that a write of one leaves it alone, and that irq_n only goes low with interrupt mode on and an enabled flag set. Whether the field comparisons themselves are right (the mask bit, the day or date choice, the 12-hour hour byte) can only be shown by the bench's vectors, which drive chosen times against chosen alarm bytes and compare the flags with hand-derived results. The set-over-clear priority and the exact interrupt combinations are also shown by directed scenarios.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int SEC_W   = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 7;
  localparam int WDAY_W  = 3;
  localparam int MDAY_W  = 6;
  localparam int AREG_W  = 8;
  localparam int MASK_B  = 7;
  localparam int DYDT_B  = 6;
  localparam int NUM_AL  = 2;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [MDAY_W-1:0] mday;
  } now_t;

  // A masked field matches always; otherwise the low bits must be equal.
  function automatic logic field_hit(input logic [AREG_W-1:0] areg,
                                     input logic [AREG_W-2:0] now);
    return areg[MASK_B] || (areg[AREG_W-2:0] == now);
  endfunction

  // Day byte: bit 6 picks day-of-week (bits 3:0) or date (bits 5:0).
  function automatic logic day_hit(input logic [AREG_W-1:0] areg,
                                   input logic [WDAY_W-1:0] wday,
                                   input logic [MDAY_W-1:0] mday);
    logic r;
    if (areg[MASK_B])
      r = 1'b1;
    else if (areg[DYDT_B])
      r = (areg[3:0] == {{(4-WDAY_W){1'b0}}, wday});
    else
      r = (areg[MDAY_W-1:0] == mday);
    return r;
  endfunction

endpackage

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  now_t              now,
  input  logic [AREG_W-1:0] sec_reg,
  input  logic [AREG_W-1:0] min_reg,
  input  logic [AREG_W-1:0] hour_reg,
  input  logic [AREG_W-1:0] day_reg,
  output logic              hit
);

  logic sec_ok;
  logic min_ok;
  logic hour_ok;
  logic day_ok;

  generate
    if (HAS_SEC) begin : g_sec_cmp
      assign sec_ok = field_hit(sec_reg, now.sec);
    end else begin : g_sec_zero
      logic unused_sec;
      assign unused_sec = ^sec_reg;
      assign sec_ok = (now.sec == '0);
    end
  endgenerate

  assign min_ok  = field_hit(min_reg, now.min);
  assign hour_ok = field_hit(hour_reg, now.hour);
  assign day_ok  = day_hit(day_reg, now.wday, now.mday);
  assign hit     = sec_ok && min_ok && hour_ok && day_ok;

endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] hit,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags
);

  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;

  assign set_v = tick ? hit : '0;
  assign clr_v = wr ? ~wdata : '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)
          flags[i] <= 1'b0;
        else if (set_v[i])
          flags[i] <= 1'b1;
        else if (clr_v[i])
          flags[i] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int N = 2
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] ie,
  input  logic         int_mode,
  output logic         irq_n
);

  logic any_req;

  assign any_req = |(flags & ie);
  assign irq_n   = ~(int_mode & any_req);

endmodule

// File: rtl/dual_alarm_match.sv
module dual_alarm_match
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic [MDAY_W-1:0] now_mday,
  input  logic [AREG_W-1:0] a1_sec,
  input  logic [AREG_W-1:0] a1_min,
  input  logic [AREG_W-1:0] a1_hour,
  input  logic [AREG_W-1:0] a1_day,
  input  logic [AREG_W-1:0] a2_min,
  input  logic [AREG_W-1:0] a2_hour,
  input  logic [AREG_W-1:0] a2_day,
  input  logic [NUM_AL-1:0] ie,
  input  logic              int_mode,
  input  logic              flag_wr,
  input  logic [NUM_AL-1:0] flag_wdata,
  output logic [NUM_AL-1:0] flags,
  output logic              irq_n
);

  now_t              now;
  logic [NUM_AL-1:0] al_hit;

  assign now = '{sec: now_sec, min: now_min, hour: now_hour,
                 wday: now_wday, mday: now_mday};

  alarm_unit #(.HAS_SEC(1'b1)) u_al1 (
    .now      (now),
    .sec_reg  (a1_sec),
    .min_reg  (a1_min),
    .hour_reg (a1_hour),
    .day_reg  (a1_day),
    .hit      (al_hit[0])
  );

  // Alarm 2 has no seconds byte: it waits for seconds == 00.
  alarm_unit #(.HAS_SEC(1'b0)) u_al2 (
    .now      (now),
    .sec_reg  ({AREG_W{1'b1}}),
    .min_reg  (a2_min),
    .hour_reg (a2_hour),
    .day_reg  (a2_day),
    .hit      (al_hit[1])
  );

  alarm_flags #(.N(NUM_AL)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .hit   (al_hit),
    .wr    (flag_wr),
    .wdata (flag_wdata),
    .flags (flags)
  );

  alarm_irq #(.N(NUM_AL)) u_irq (
    .flags    (flags),
    .ie       (ie),
    .int_mode (int_mode),
    .irq_n    (irq_n)
  );

endmodule

// File: rtl/alarm_checker.sv
module alarm_checker
  import alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [SEC_W-1:0]  now_sec,
  input logic              flag_wr,
  input logic [NUM_AL-1:0] flag_wdata,
  input logic [NUM_AL-1:0] ie,
  input logic              int_mode,
  input logic [NUM_AL-1:0] flags,
  input logic              irq_n,
  input logic [NUM_AL-1:0] hit
);

  generate
    for (genvar g = 0; g < NUM_AL; g++) begin : g_chk
      // R4: a flag only rises on the edge after a strobe
      a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[g]) |-> $past(tick));
      // R4: a strobed match always sets the flag
      a_r4_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit[g]) |=> flags[g]);
      // R4: sticky unless a clearing write arrives
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[g] && !(flag_wr && !flag_wdata[g])) |=> flags[g]);
      // R6: writing a one leaves the flag alone
      a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[g] && !tick) |=> $stable(flags[g]));
      // R6: writing a zero without a match clears
      a_r6_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[g] && !(tick && hit[g])) |=> !flags[g]);
    end
  endgenerate

  // R5: alarm 2 rises only after seconds were zero
  a_r5_a2_top_of_minute: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> ($past(now_sec) == '0));

  // R8: no interrupt outside interrupt mode
  a_r8_mode_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> irq_n);

  // R8: a low interrupt has an enabled flag behind it
  a_r8_low_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|(flags & ie)));

endmodule

bind dual_alarm_match alarm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .now_sec    (now_sec),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .ie         (ie),
  .int_mode   (int_mode),
  .flags      (flags),
  .irq_n      (irq_n),
  .hit        (al_hit)
);

// File: tb/tb_dual_alarm_match.sv
`timescale 1ns/1ps
module tb_dual_alarm_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [2:0] now_wday = 3'd1;
  logic [5:0] now_mday = 6'h01;
  logic [7:0] a1_sec = 8'h80, a1_min = 8'h80, a1_hour = 8'h80, a1_day = 8'h80;
  logic [7:0] a2_min = 8'h80, a2_hour = 8'h80, a2_day = 8'h80;
  logic [1:0] ie = 2'b00;
  logic       int_mode = 1'b0;
  logic       flag_wr = 1'b0;
  logic [1:0] flag_wdata = 2'b11;
  logic [1:0] flags;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_alarm_match dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .a1_sec(a1_sec), .a1_min(a1_min), .a1_hour(a1_hour), .a1_day(a1_day),
    .a2_min(a2_min), .a2_hour(a2_hour), .a2_day(a2_day),
    .ie(ie), .int_mode(int_mode), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .flags(flags), .irq_n(irq_n)
  );

  // {sec,min,hour,wday,mday, a1 sec,min,hour,day, a2 min,hour,day, expected flags}
  localparam int NV = 8;
  localparam logic [87:0] VEC [NV] = '{
    {7'h56,7'h34,7'h12,3'd3,6'h15, 8'h56,8'h34,8'h12,8'h80, 8'h80,8'h80,8'h80, 2'b01},
    {7'h56,7'h34,7'h12,3'd3,6'h15, 8'h57,8'h34,8'h12,8'h80, 8'h80,8'h80,8'h80, 2'b00},
    {7'h00,7'h34,7'h12,3'd3,6'h15, 8'h80,8'h80,8'h80,8'h80, 8'h34,8'h12,8'h15, 2'b11},
    {7'h00,7'h34,7'h12,3'd3,6'h15, 8'h01,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h43, 2'b10},
    {7'h00,7'h34,7'h12,3'd3,6'h15, 8'h01,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h44, 2'b00},
    {7'h20,7'h05,7'h71,3'd1,6'h02, 8'h80,8'h80,8'h71,8'h80, 8'h80,8'h80,8'h80, 2'b01},
    {7'h20,7'h05,7'h71,3'd1,6'h02, 8'h80,8'h80,8'h51,8'h80, 8'h80,8'h80,8'h80, 2'b00},
    {7'h30,7'h59,7'h23,3'd7,6'h31, 8'h80,8'h80,8'h80,8'h31, 8'h80,8'h80,8'h80, 2'b01}
  };

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 2'b00;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = 2'b11;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic all_masked();
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_day = 8'h80;
    a2_min = 8'h80; a2_hour = 8'h80; a2_day = 8'h80;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flags in reset", flags, 2'b00);
    check("R1 irq_n in reset", {1'b0, irq_n}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", flags, 2'b00);

    // Table: R2 field match and mask, R3 day/date, R5 alarm 2 at second 00
    for (int i = 0; i < NV; i++) begin
      logic [87:0] v;
      v = VEC[i];
      now_sec = v[87:81]; now_min = v[80:74]; now_hour = v[73:67];
      now_wday = v[66:64]; now_mday = v[63:58];
      a1_sec = v[57:50]; a1_min = v[49:42]; a1_hour = v[41:34]; a1_day = v[33:26];
      a2_min = v[25:18]; a2_hour = v[17:10]; a2_day = v[9:2];
      clear_flags();
      pulse_tick();
      check($sformatf("R2/R3/R5 vector %0d", i), flags, v[1:0]);
    end

    // R4: a match without tick sets nothing
    all_masked();
    now_sec = 7'h10;
    clear_flags();
    repeat (3) @(negedge clk);
    check("R4 no tick no flag", flags, 2'b00);
    pulse_tick();
    check("R4 tick sets flag", flags, 2'b01);
    a1_sec = 8'h59;
    pulse_tick();
    pulse_tick();
    check("R4 flag sticky without match", flags, 2'b01);

    // R6: write one keeps, write zero clears
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 2'b11;
    @(negedge clk);
    flag_wr = 1'b0;
    check("R6 write ones keeps", flags, 2'b01);
    flag_wr = 1'b1; flag_wdata = 2'b10;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = 2'b11;
    check("R6 write zero clears", flags, 2'b00);

    // R7: set wins over a same-cycle clear
    all_masked();
    @(negedge clk);
    tick = 1'b1; flag_wr = 1'b1; flag_wdata = 2'b00;
    @(negedge clk);
    tick = 1'b0; flag_wr = 1'b0; flag_wdata = 2'b11;
    check("R7 set beats clear", flags, 2'b01);

    // R8: interrupt combinations with flags = 01
    ie = 2'b01; int_mode = 1'b1;
    #1 check("R8 enabled flag drives irq low", {1'b0, irq_n}, 2'b00);
    ie = 2'b10;
    #1 check("R8 disabled flag keeps irq high", {1'b0, irq_n}, 2'b01);
    ie = 2'b11; int_mode = 1'b0;
    #1 check("R8 mode off keeps irq high", {1'b0, irq_n}, 2'b01);
    int_mode = 1'b1;
    clear_flags();
    check("R8 no flag keeps irq high", {1'b0, irq_n}, 2'b01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule